// File: doc/BRIEF.md
# Receive/Transmit Ready Pin Generator

This block drives the two active-low ready pins that a 16550-style serial port offers to an external block-transfer engine or host: one tells the host that received characters can be collected, the other that the transmitter can accept characters. It does not hold any data. It watches the occupancy counts of the 32-entry receive and transmit FIFOs, the programmed receive trigger level, a receive character-timeout strobe and two mode bits: one enables the FIFOs and one selects block-transfer operation. From these it forms the pin levels.

There are three behaviours. In character mode (FIFOs off), each pin reports whether the single holding register is occupied. In FIFO mode without block transfer, the receive pin reports "any data present" and the transmit pin reports "FIFO fully empty". In block-transfer mode the receive pin has hysteresis. It asserts once the count reaches the trigger level or a timeout fires, and it stays asserted until the FIFO drains to zero, so the host can unload a whole block on one request. In the same mode the transmit pin asserts while any slot is free.

Both pins are registered. Each pin therefore shows what the inputs were one clock earlier. A synchronous reset, or any change of the two mode bits, discards the latched receive request.

Top module: `rdy_pins_gen`

## Requirements
- R1: While `rst` is high, both pins read 1 on the following clock edge. After reset the latched receive request is clear, so in block mode a count below the trigger leaves `rxrdy_n` at 1.
- R2: In character mode (`fifo_en`=0), `rxrdy_n` is 0 when `rx_count` is 1 and 1 when `rx_count` is 0.
- R3: In character mode, `txrdy_n` is 0 when `tx_count` is 0 and 1 when `tx_count` is 1.
- R4: In FIFO mode (`fifo_en`=1, `blk_mode`=0), `rxrdy_n` is 0 when `rx_count` is at least 1 and 1 when it is 0.
- R5: In FIFO mode, `txrdy_n` is 0 only when `tx_count` is 0. For any count from 1 to 32 it is 1.
- R6: In block mode (`fifo_en`=1, `blk_mode`=1), `rxrdy_n` falls to 0 when `rx_count` is greater than or equal to `rx_trig`. This includes the case where the count equals the trigger.
- R7: In block mode, a one-cycle `rx_timeout` pulse with a nonzero `rx_count` drives `rxrdy_n` to 0, even when the count is below the trigger.
- R8: In block mode, once `rxrdy_n` is 0 it stays 0 while `rx_count` is nonzero, even when the count falls below the trigger.
- R9: In block mode, `rxrdy_n` returns to 1 when `rx_count` is 0. A timeout pulse in the same cycle as a zero count does not assert it.
- R10: In block mode, `txrdy_n` is 1 only when `tx_count` equals 32 (full). For 0 to 31 it is 0.
- R11: In block mode, if the pair {`fifo_en`,`blk_mode`} differs from its value in the previous cycle, the latched request is cleared and `rxrdy_n` is 1 on the next edge, whatever the count.
- R12: Each pin changes on the first clock edge after its inputs change, and not before.
- R13: With `fifo_en`=0 the block is in character mode whatever the value of `blk_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO enable mode bit |
| blk_mode | input | 1 | Block-transfer mode bit |
| rx_count | input | 6 | Receive occupancy, 0 to 32 |
| tx_count | input | 6 | Transmit occupancy, 0 to 32 |
| rx_trig | input | 5 | Receive trigger level, 1 to 31 |
| rx_timeout | input | 1 | One-cycle receive character-timeout strobe |
| rxrdy_n | output | 1 | Receive ready pin, active low |
| txrdy_n | output | 1 | Transmit ready pin, active low |

## Verification
The properties assume that the occupancy inputs never go above the FIFO depth and that the trigger level lies between 1 and 31. In character mode they also assume the counts stay at 0 or 1, as a holding register would report them. The full-slot property for the transmit pin depends on a count of exactly 32 meaning full. The stimulus uses only counts from 0 to 32 and triggers of 1, 8 and 31, and it holds character-mode counts at 0 or 1. Its mode changes occur only at vector boundaries, so each latched-request clear lines up with exactly one observed edge.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    typedef enum logic [1:0] {
        MODE_CHAR  = 2'd0,
        MODE_FIFO  = 2'd1,
        MODE_BLOCK = 2'd2
    } xfer_mode_e;

    typedef struct packed {
        logic [1:0] fcr_bits;
        logic       rx_held;
        logic       rxrdy_n;
        logic       txrdy_n;
    } rdy_state_t;

endpackage

// File: rtl/rdy_mode_dec.sv
module rdy_mode_dec
    import rdy_pkg::*;
(
    input  logic       fifo_en,
    input  logic       blk_mode,
    output xfer_mode_e mode
);
    always_comb begin
        if (!fifo_en) begin
            mode = MODE_CHAR;
        end else if (blk_mode) begin
            mode = MODE_BLOCK;
        end else begin
            mode = MODE_FIFO;
        end
    end
endmodule

// File: rtl/rdy_rx_next.sv
module rdy_rx_next
    import rdy_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int TRIG_W = 5
) (
    input  xfer_mode_e        mode,
    input  logic              mode_chg,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic              rx_timeout,
    input  logic              held_q,
    output logic              held_d,
    output logic              rxrdy_n_d
);
    logic empty;
    logic at_trig;

    assign empty   = (rx_count == '0);
    assign at_trig = (rx_count >= CNT_W'(rx_trig));

    always_comb begin
        held_d = held_q;
        if (mode != MODE_BLOCK || mode_chg) begin
            held_d = 1'b0;
        end else if (empty) begin
            // drain wins over a simultaneous timeout
            held_d = 1'b0;
        end else if (at_trig || rx_timeout) begin
            held_d = 1'b1;
        end

        if (mode == MODE_BLOCK) begin
            rxrdy_n_d = !held_d;
        end else begin
            rxrdy_n_d = empty;
        end
    end
endmodule

// File: rtl/rdy_tx_next.sv
module rdy_tx_next
    import rdy_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input  xfer_mode_e       mode,
    input  logic [CNT_W-1:0] tx_count,
    output logic             txrdy_n_d
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    always_comb begin
        if (mode == MODE_BLOCK) begin
            txrdy_n_d = (tx_count >= FULL_CNT);
        end else begin
            txrdy_n_d = (tx_count != '0);
        end
    end
endmodule

// File: rtl/rdy_pins_gen.sv
module rdy_pins_gen
    import rdy_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int TRIG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              blk_mode,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic              rx_timeout,
    output logic              rxrdy_n,
    output logic              txrdy_n
);
    rdy_state_t st_d;
    rdy_state_t st_q;
    xfer_mode_e mode;
    logic [1:0] fcr_bits;
    logic       mode_chg;
    logic       held_d;
    logic       rxrdy_n_d;
    logic       txrdy_n_d;

    assign fcr_bits = {fifo_en, blk_mode};
    assign mode_chg = (fcr_bits != st_q.fcr_bits);

    rdy_mode_dec u_dec (
        .fifo_en  (fifo_en),
        .blk_mode (blk_mode),
        .mode     (mode)
    );

    rdy_rx_next #(
        .CNT_W  (CNT_W),
        .TRIG_W (TRIG_W)
    ) u_rx (
        .mode       (mode),
        .mode_chg   (mode_chg),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .held_q     (st_q.rx_held),
        .held_d     (held_d),
        .rxrdy_n_d  (rxrdy_n_d)
    );

    rdy_tx_next #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_tx (
        .mode      (mode),
        .tx_count  (tx_count),
        .txrdy_n_d (txrdy_n_d)
    );

    always_comb begin
        st_d          = st_q;
        st_d.fcr_bits = fcr_bits;
        st_d.rx_held  = held_d;
        st_d.rxrdy_n  = rxrdy_n_d;
        st_d.txrdy_n  = txrdy_n_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            // mode bits keep tracking so release does not look like a change
            st_q.fcr_bits <= fcr_bits;
            st_q.rx_held  <= 1'b0;
            st_q.rxrdy_n  <= 1'b1;
            st_q.txrdy_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rxrdy_n = st_q.rxrdy_n;
    assign txrdy_n = st_q.txrdy_n;
endmodule

// File: rtl/rdy_pins_gen_chk.sv
module rdy_pins_gen_chk #(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6,
    parameter int TRIG_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_en,
    input logic              blk_mode,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  tx_count,
    input logic [TRIG_W-1:0] rx_trig,
    input logic              rx_timeout,
    input logic              rxrdy_n,
    input logic              txrdy_n
);
    logic blk;
    assign blk = fifo_en && blk_mode;

    assert_reset_high_R1: assert property (@(posedge clk)
        rst |=> (rxrdy_n && txrdy_n));

    assert_tx_nonblock_R5: assert property (@(posedge clk) disable iff (rst)
        (!blk && tx_count != '0) |=> txrdy_n);

    assert_tx_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (!blk && tx_count == '0) |=> !txrdy_n);

    assert_tx_full_R10: assert property (@(posedge clk) disable iff (rst)
        (blk && tx_count == CNT_W'(DEPTH)) |=> txrdy_n);

    assert_tx_slot_R10: assert property (@(posedge clk) disable iff (rst)
        (blk && tx_count < CNT_W'(DEPTH)) |=> !txrdy_n);

    assert_rx_drain_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |=> rxrdy_n);

    assert_rx_nonblock_R4: assert property (@(posedge clk) disable iff (rst)
        (!blk && rx_count != '0) |=> !rxrdy_n);

    assert_rx_set_R6: assert property (@(posedge clk) disable iff (rst)
        (blk && $stable({fifo_en, blk_mode}) && rx_count != '0
         && (rx_count >= CNT_W'(rx_trig) || rx_timeout)) |=> !rxrdy_n);

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (blk && $stable({fifo_en, blk_mode}) && !rxrdy_n && rx_count != '0)
        |=> !rxrdy_n);

    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (blk && !$stable({fifo_en, blk_mode})) |=> rxrdy_n);
endmodule

bind rdy_pins_gen rdy_pins_gen_chk #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .TRIG_W (TRIG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .blk_mode   (blk_mode),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_trig    (rx_trig),
    .rx_timeout (rx_timeout),
    .rxrdy_n    (rxrdy_n),
    .txrdy_n    (txrdy_n)
);

// File: tb/rdy_pins_gen_test.sv
module rdy_pins_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0;
    logic       blk_mode = 1'b0;
    logic [5:0] rx_count = '0;
    logic [5:0] tx_count = '0;
    logic [4:0] rx_trig = 5'd8;
    logic       rx_timeout = 1'b0;
    logic       rxrdy_n;
    logic       txrdy_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdy_pins_gen uut (
        .clk        (clk),
        .rst        (rst),
        .fifo_en    (fifo_en),
        .blk_mode   (blk_mode),
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .rxrdy_n    (rxrdy_n),
        .txrdy_n    (txrdy_n)
    );

    // fields: fifo_en, blk_mode, rx_count, tx_count, rx_trig, rx_timeout, exp rx, exp tx
    localparam logic [21:0] VECS [0:NVEC-1] = '{
        {1'b0, 1'b0, 6'd0,  6'd0,  5'd8,  1'b0, 1'b1, 1'b0}, // R2 R3 idle char
        {1'b0, 1'b0, 6'd1,  6'd1,  5'd8,  1'b0, 1'b0, 1'b1}, // R2 R3 both held
        {1'b0, 1'b1, 6'd1,  6'd0,  5'd8,  1'b0, 1'b0, 1'b0}, // R13 block bit alone
        {1'b0, 1'b1, 6'd0,  6'd1,  5'd8,  1'b0, 1'b1, 1'b1}, // R13
        {1'b1, 1'b0, 6'd5,  6'd0,  5'd8,  1'b0, 1'b0, 1'b0}, // R4 R5
        {1'b1, 1'b0, 6'd32, 6'd31, 5'd8,  1'b0, 1'b0, 1'b1}, // R4 R5
        {1'b1, 1'b0, 6'd0,  6'd32, 5'd8,  1'b0, 1'b1, 1'b1}, // R4 R5
        {1'b1, 1'b1, 6'd20, 6'd0,  5'd8,  1'b0, 1'b1, 1'b0}, // R11 entry clears
        {1'b1, 1'b1, 6'd20, 6'd31, 5'd8,  1'b0, 1'b0, 1'b0}, // R6 R10
        {1'b1, 1'b1, 6'd3,  6'd32, 5'd8,  1'b0, 1'b0, 1'b1}, // R8 R10 full
        {1'b1, 1'b1, 6'd1,  6'd32, 5'd8,  1'b0, 1'b0, 1'b1}, // R8
        {1'b1, 1'b1, 6'd0,  6'd5,  5'd8,  1'b0, 1'b1, 1'b0}, // R9 drain
        {1'b1, 1'b1, 6'd3,  6'd0,  5'd8,  1'b0, 1'b1, 1'b0}, // R6 below trigger
        {1'b1, 1'b1, 6'd7,  6'd0,  5'd8,  1'b0, 1'b1, 1'b0}, // R6 one short
        {1'b1, 1'b1, 6'd8,  6'd0,  5'd8,  1'b0, 1'b0, 1'b0}, // R6 exact trigger
        {1'b1, 1'b1, 6'd0,  6'd0,  5'd8,  1'b0, 1'b1, 1'b0}, // R9
        {1'b1, 1'b1, 6'd2,  6'd0,  5'd8,  1'b1, 1'b0, 1'b0}, // R7 timeout
        {1'b1, 1'b1, 6'd2,  6'd0,  5'd8,  1'b0, 1'b0, 1'b0}, // R8 hold
        {1'b1, 1'b1, 6'd0,  6'd0,  5'd8,  1'b1, 1'b1, 1'b0}, // R9 drain beats timeout
        {1'b1, 1'b1, 6'd1,  6'd0,  5'd1,  1'b0, 1'b0, 1'b0}, // R6 trigger of 1
        {1'b1, 1'b1, 6'd31, 6'd0,  5'd31, 1'b0, 1'b0, 1'b0}, // R6 trigger of 31
        {1'b1, 1'b0, 6'd31, 6'd0,  5'd31, 1'b0, 1'b0, 1'b0}, // R4 leave block
        {1'b1, 1'b1, 6'd31, 6'd0,  5'd31, 1'b0, 1'b1, 1'b0}  // R11 re-entry clears
    };

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 rx reset", rxrdy_n, 1'b1);
        check("R1 tx reset", txrdy_n, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {fifo_en, blk_mode, rx_count, tx_count, rx_trig, rx_timeout} = VECS[i][21:2];
            @(posedge clk);
            #1;
            check($sformatf("vector %0d rx", i), rxrdy_n, VECS[i][1]);
            check($sformatf("vector %0d tx", i), txrdy_n, VECS[i][0]);
        end

        // R12: block mode, count crosses the trigger; pin waits for the edge
        @(negedge clk);
        rx_timeout = 1'b0;
        rx_trig    = 5'd8;
        rx_count   = 6'd9;
        #1;
        check("R12 before edge", rxrdy_n, 1'b1);
        @(posedge clk);
        #1;
        check("R12 after edge", rxrdy_n, 1'b0);

        // R1: reset with the request latched and transmitter full
        @(negedge clk);
        tx_count = 6'd32;
        rst      = 1'b1;
        @(posedge clk);
        #1;
        check("R1 rx in reset", rxrdy_n, 1'b1);
        check("R1 tx in reset", txrdy_n, 1'b1);
        @(negedge clk);
        rst      = 1'b0;
        rx_count = 6'd5;
        tx_count = 6'd0;
        @(posedge clk);
        #1;
        check("R1 latch cleared", rxrdy_n, 1'b1);
        check("R10 slot free", txrdy_n, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule